// File: doc/BRIEF.md
# Programmable Watchdog Timer with Shaped Reset Output

This block is a watchdog peripheral. It is programmed through a small byte-wide register port. Software writes a timeout count, picks a time unit of one second or one minute, and turns counting on. The block derives its unit strobes from a 1 ms tick input and counts the programmed value down. When the count runs out, it sets a sticky timeout flag. Software clears that flag by writing a one to it.

On timeout the block drives a reset output. The reset output's polarity can be chosen, and it can behave in one of two ways. In level mode it holds while the flag is set. In pulse mode it gives one pulse whose length is taken from four widths. A second timeout output follows the flag only when its own enable is set. An early-warning flag, which can also be switched on or off, shows that one unit is left before expiry. Writing the timeout register reloads the count, and that restarts the watchdog.

Top module: `wdt_core`

## Requirements
- R1: After reset every register reads 0, `rst_out` is 1 (inactive, since the reset polarity is low-active), and both `tmo_out` and `pme_out` are 0.
- R2: A write to the timeout register (select 1) reloads the count and restarts the unit prescaler. With counting enabled and ticks arriving every cycle, the status flag (select 0, bit 6) reads 1 exactly T×U clock edges after the write edge. Here T is the written value and U is the number of ticks per unit.
- R3: Bit 3 of register 0 selects the unit. 0 means U = TICKS_PER_SEC ticks, and 1 means U = TICKS_PER_SEC×SECS_PER_MIN ticks.
- R4: Bit 5 of register 0 enables counting. While it is 0 the count does not move. While `tick_1ms` is low the count does not advance either.
- R5: A timeout value of 0 never produces a timeout.
- R6: Writing register 0 with bit 6 set clears the status flag. Writing it with bit 6 at 0 leaves the flag unchanged. A timeout in the same cycle as a clear wins.
- R7: In level mode (register 0 bit 4 = 0) the reset output is active for as long as the status flag is set. It goes inactive on the edge that clears the flag.
- R8: In pulse mode (bit 4 = 1) the reset output is active for exactly PW_TICKS_n ticks, starting at the timeout edge. The code n is register 0 bits 1:0, and codes 0 to 3 default to 1 ms, 25 ms, 125 ms and 5 s. The pulse ends even while the flag stays set.
- R9: Register 0 bit 2 sets the polarity. With bit 2 = 1 an active reset drives `rst_out` high. With bit 2 = 0 it drives `rst_out` low.
- R10: With register 2 bit 6 set, `pme_out` and register 2 bit 7 are 1 exactly while counting is enabled and one unit remains. That condition first occurs (T−1)×U edges after the reload.
- R11: Register 2 bit 0 enables `tmo_out`. `tmo_out` is 1 only when this bit and the status flag are both 1.
- R12: Register 0 bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle strobe, once per millisecond |
| reg_sel | input | 2 | Register select: 0 config, 1 timeout, 2 warning/output control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rst_out | output | 1 | Shaped reset output with selectable polarity |
| tmo_out | output | 1 | Gated timeout output, active high |
| pme_out | output | 1 | Early-warning event, active high |

## Verification
A write takes effect on the clock edge that samples it. Read data and the three outputs are combinational from registers, so every result can be observed at the falling edge after that write edge. The expiry flag is due T×U edges after the reload edge and the warning is due (T−1)×U edges after it. A pulse stays active for exactly PW_TICKS_n falling-edge samples, starting at the expiry sample. The bench waits on these quantities by counting falling edges from the write and compares the counts with values computed from the parameters, so a result that arrives one cycle early or late is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } wdt_sel_e;

  // bit positions in the configuration register
  localparam int B_STS   = 6;
  localparam int B_EN    = 5;
  localparam int B_PULSE = 4;
  localparam int B_UNIT  = 3;
  localparam int B_HACT  = 2;

  // bit positions in the control register
  localparam int B_WFLAG = 7;
  localparam int B_WEN   = 6;
  localparam int B_OEN   = 0;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdt_unit_gen.sv
module wdt_unit_gen #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic unit_min,
  output logic unit_stb
);
  localparam int SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [SW-1:0] SEC_LAST = SW'(TICKS_PER_SEC - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(SECS_PER_MIN - 1);

  logic [SW-1:0] sec_q, sec_d;
  logic [MW-1:0] min_q, min_d;
  logic          sec_wrap, min_wrap, active;

  assign active   = run && !restart;
  assign sec_wrap = active && tick && (sec_q == SEC_LAST);
  assign min_wrap = sec_wrap && (min_q == MIN_LAST);
  assign unit_stb = unit_min ? min_wrap : sec_wrap;

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    if (!active) begin
      sec_d = '0;
      min_d = '0;
    end else if (tick) begin
      sec_d = sec_wrap ? '0 : sec_q + 1'b1;
      if (sec_wrap) min_d = min_wrap ? '0 : min_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
    end
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  logic [CW-1:0] cnt_d;
  logic          nonzero;

  assign nonzero = |cnt;
  assign expire  = step && !load && (cnt == CW'(1));

  always_comb begin
    cnt_d = cnt;
    if (load)                 cnt_d = load_val;
    else if (step && nonzero) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wdt_rst_shaper.sv
module wdt_rst_shaper
  import wdt_pkg::*;
#(
  parameter int PW_TICKS_0 = 1,
  parameter int PW_TICKS_1 = 25,
  parameter int PW_TICKS_2 = 125,
  parameter int PW_TICKS_3 = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fire,
  input  logic       pulse_mode,
  input  logic [1:0] pw_sel,
  input  logic       level_hold,
  input  logic       act_hi,
  output logic       rst_out
);
  localparam int PMAX = max4(PW_TICKS_0, PW_TICKS_1, PW_TICKS_2, PW_TICKS_3);
  localparam int PCW  = $clog2(PMAX + 1);

  logic [PCW-1:0] pcnt_q, pcnt_d, width;
  logic           pulse_on, act;

  always_comb begin
    unique case (pw_sel)
      2'd0:    width = PCW'(PW_TICKS_0);
      2'd1:    width = PCW'(PW_TICKS_1);
      2'd2:    width = PCW'(PW_TICKS_2);
      default: width = PCW'(PW_TICKS_3);
    endcase
  end

  assign pulse_on = |pcnt_q;

  always_comb begin
    pcnt_d = pcnt_q;
    if (fire && pulse_mode)   pcnt_d = width;
    else if (tick && pulse_on) pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign act     = pulse_mode ? pulse_on : level_hold;
  assign rst_out = act ? act_hi : !act_hi;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60,
  parameter int PW_TICKS_0    = 1,
  parameter int PW_TICKS_1    = 25,
  parameter int PW_TICKS_2    = 125,
  parameter int PW_TICKS_3    = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rst_out,
  output logic       tmo_out,
  output logic       pme_out
);
  localparam int CW = 8;

  logic          cfg_en, cfg_pulse, cfg_unit, cfg_hact;
  logic [1:0]    cfg_pw;
  logic          status_q, pme_en_q, out_en_q;
  logic [CW-1:0] tmr_q;
  logic          cfg_en_d, cfg_pulse_d, cfg_unit_d, cfg_hact_d;
  logic [1:0]    cfg_pw_d;
  logic          status_d, pme_en_d, out_en_d;
  logic [CW-1:0] tmr_d;
  logic          cfg_wr, tmr_wr, ctl_wr;
  logic          unit_stb, expire;
  logic [CW-1:0] cur_cnt;

  assign cfg_wr = reg_wr && (wdt_sel_e'(reg_sel) == SEL_CFG);
  assign tmr_wr = reg_wr && (wdt_sel_e'(reg_sel) == SEL_TIME);
  assign ctl_wr = reg_wr && (wdt_sel_e'(reg_sel) == SEL_CTL);

  wdt_unit_gen #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SECS_PER_MIN (SECS_PER_MIN)
  ) u_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1ms),
    .run     (cfg_en),
    .restart (tmr_wr),
    .unit_min(cfg_unit),
    .unit_stb(unit_stb)
  );

  wdt_down_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_wr),
    .load_val(reg_wdata),
    .step    (unit_stb),
    .cnt     (cur_cnt),
    .expire  (expire)
  );

  wdt_rst_shaper #(
    .PW_TICKS_0(PW_TICKS_0),
    .PW_TICKS_1(PW_TICKS_1),
    .PW_TICKS_2(PW_TICKS_2),
    .PW_TICKS_3(PW_TICKS_3)
  ) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1ms),
    .fire      (expire),
    .pulse_mode(cfg_pulse),
    .pw_sel    (cfg_pw),
    .level_hold(status_q),
    .act_hi    (cfg_hact),
    .rst_out   (rst_out)
  );

  always_comb begin
    cfg_en_d    = cfg_en;
    cfg_pulse_d = cfg_pulse;
    cfg_unit_d  = cfg_unit;
    cfg_hact_d  = cfg_hact;
    cfg_pw_d    = cfg_pw;
    tmr_d       = tmr_q;
    pme_en_d    = pme_en_q;
    out_en_d    = out_en_q;
    status_d    = status_q;
    if (cfg_wr) begin
      cfg_en_d    = reg_wdata[B_EN];
      cfg_pulse_d = reg_wdata[B_PULSE];
      cfg_unit_d  = reg_wdata[B_UNIT];
      cfg_hact_d  = reg_wdata[B_HACT];
      cfg_pw_d    = reg_wdata[1:0];
      if (reg_wdata[B_STS]) status_d = 1'b0;
    end
    if (tmr_wr) tmr_d = reg_wdata;
    if (ctl_wr) begin
      pme_en_d = reg_wdata[B_WEN];
      out_en_d = reg_wdata[B_OEN];
    end
    if (expire) status_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_pulse <= 1'b0;
      cfg_unit  <= 1'b0;
      cfg_hact  <= 1'b0;
      cfg_pw    <= 2'd0;
      tmr_q     <= '0;
      pme_en_q  <= 1'b0;
      out_en_q  <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      cfg_en    <= cfg_en_d;
      cfg_pulse <= cfg_pulse_d;
      cfg_unit  <= cfg_unit_d;
      cfg_hact  <= cfg_hact_d;
      cfg_pw    <= cfg_pw_d;
      tmr_q     <= tmr_d;
      pme_en_q  <= pme_en_d;
      out_en_q  <= out_en_d;
      status_q  <= status_d;
    end
  end

  assign pme_out = pme_en_q && cfg_en && (cur_cnt == CW'(1));
  assign tmo_out = out_en_q && status_q;

  always_comb begin
    unique case (wdt_sel_e'(reg_sel))
      SEL_CFG:  reg_rdata = {1'b0, status_q, cfg_en, cfg_pulse, cfg_unit, cfg_hact, cfg_pw};
      SEL_TIME: reg_rdata = tmr_q;
      SEL_CTL:  reg_rdata = {pme_out, pme_en_q, 5'b0, out_en_q};
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_rdata,
  input logic       rst_out,
  input logic       tmo_out,
  input logic       pme_out,
  input logic       status_q,
  input logic       cfg_en,
  input logic       cfg_pulse,
  input logic       cfg_hact,
  input logic       out_en_q,
  input logic       tmr_wr,
  input logic [7:0] cur_cnt
);
  assert_expire_from_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> ($past(cur_cnt) == 8'd1));

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !tmr_wr) |=> $stable(cur_cnt));

  assert_zero_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt == 8'd0 && !tmr_wr) |=> (cur_cnt == 8'd0));

  assert_level_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q) && !cfg_pulse) |-> (rst_out == cfg_hact));

  assert_warn_one_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pme_out |-> (cur_cnt == 8'd1));

  assert_tmo_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_q |-> !tmo_out);

  assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> !reg_rdata[7]);
endmodule

bind wdt_core wdt_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .reg_rdata(reg_rdata),
  .rst_out  (rst_out),
  .tmo_out  (tmo_out),
  .pme_out  (pme_out),
  .status_q (status_q),
  .cfg_en   (cfg_en),
  .cfg_pulse(cfg_pulse),
  .cfg_hact (cfg_hact),
  .out_en_q (out_en_q),
  .tmr_wr   (tmr_wr),
  .cur_cnt  (cur_cnt)
);

// File: tb/wdt_core_bench.sv
`timescale 1ns/1ps
module wdt_core_bench;
  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam int PW0 = 1, PW1 = 2, PW2 = 3, PW3 = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rst_out, tmo_out, pme_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  wdt_core #(
    .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
    .PW_TICKS_0(PW0), .PW_TICKS_1(PW1), .PW_TICKS_2(PW2), .PW_TICKS_3(PW3)
  ) u_wdt_core (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_out(rst_out),
    .tmo_out(tmo_out), .pme_out(pme_out)
  );

  function automatic int unit_ticks(input bit umin);
    return umin ? TPS * SPM : TPS;
  endfunction

  function automatic int pw_ticks(input int code);
    case (code)
      0: return PW0;
      1: return PW1;
      2: return PW2;
      default: return PW3;
    endcase
  endfunction

  function automatic logic [7:0] cfg_byte(input bit w1c, input bit en, input bit pulse,
                                          input bit umin, input bit hact, input int pw);
    return {1'b0, w1c, en, pulse, umin, hact, 2'(pw)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one full expiry scenario, checks R2/R3/R7/R8/R9/R10/R11
  task automatic run_timeout(input int t, input bit umin, input bit pulse, input bit hact,
                             input int pw, input bit wen, input bit oen);
    int n, pme_first, exp_n, m;
    logic [7:0] d;
    wr(2'd2, {1'b0, wen, 5'b0, oen});
    wr(2'd0, cfg_byte(1'b1, 1'b1, pulse, umin, hact, pw));
    wr(2'd1, 8'(t));
    reg_sel = 2'd0; #1;
    exp_n = t * unit_ticks(umin);
    n = 0; pme_first = -1;
    while (n < 1000) begin
      if (pme_out && pme_first < 0) pme_first = n;
      if (reg_rdata[6]) break;
      chk(rst_out == !hact, "R9 idle polarity", rst_out, !hact);
      @(negedge clk); #1; n++;
    end
    chk(n == exp_n, umin ? "R3 minute unit expiry edges" : "R2 second unit expiry edges", n, exp_n);
    chk(pme_first == (wen ? (t - 1) * unit_ticks(umin) : -1), "R10 warning onset", pme_first,
        wen ? (t - 1) * unit_ticks(umin) : -1);
    chk(pme_out == 1'b0, "R10 warning gone at expiry", pme_out, 0);
    chk(tmo_out == oen, "R11 gated timeout output", tmo_out, oen);
    if (pulse) begin
      m = 0;
      while (rst_out == hact && m < 100) begin
        @(negedge clk); #1; m++;
      end
      chk(m == pw_ticks(pw), "R8 pulse width", m, pw_ticks(pw));
      rd(2'd0, d);
      chk(d[6] == 1'b1, "R8 flag stays set after pulse", d[6], 1);
    end else begin
      repeat (7) @(negedge clk);
      #1;
      chk(rst_out == hact, "R7 level held", rst_out, hact);
      wr(2'd0, cfg_byte(1'b0, 1'b1, pulse, umin, hact, pw));
      rd(2'd0, d);
      chk(d[6] == 1'b1, "R6 write zero keeps flag", d[6], 1);
      chk(rst_out == hact, "R7 level after zero write", rst_out, hact);
    end
    wr(2'd0, cfg_byte(1'b1, 1'b0, pulse, umin, hact, pw));
    rd(2'd0, d);
    chk(d[6] == 1'b0, "R6 flag cleared by one", d[6], 0);
    chk(rst_out == !hact, "R7 reset released on clear", rst_out, !hact);
    chk(tmo_out == 1'b0, "R11 output drops with flag", tmo_out, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        summary_and_end();
      end
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      rd(2'(s), d);
      chk(d == 8'h00, "R1 register reset value", d, 0);
    end
    chk(rst_out == 1'b1, "R1 reset output idle", rst_out, 1);
    chk(tmo_out == 1'b0 && pme_out == 1'b0, "R1 outputs idle", {tmo_out, pme_out}, 0);

    // R12 reserved bit
    wr(2'd0, 8'hFF);
    rd(2'd0, d);
    chk(d[7] == 1'b0, "R12 reserved bit reads zero", d[7], 0);
    wr(2'd0, 8'h40);

    // R5 zero timeout never expires
    wr(2'd0, cfg_byte(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0));
    wr(2'd1, 8'd0);
    repeat (100) @(negedge clk);
    rd(2'd0, d);
    chk(d[6] == 1'b0, "R5 zero timeout no expiry", d[6], 0);

    // R4 disabled count
    wr(2'd0, cfg_byte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0));
    wr(2'd1, 8'd2);
    repeat (100) @(negedge clk);
    rd(2'd0, d);
    chk(d[6] == 1'b0, "R4 no expiry while disabled", d[6], 0);

    // R4 no ticks means no progress
    wr(2'd0, cfg_byte(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0));
    @(negedge clk); tick = 1'b0;
    wr(2'd1, 8'd2);
    repeat (50) @(negedge clk);
    rd(2'd0, d);
    chk(d[6] == 1'b0, "R4 no expiry without ticks", d[6], 0);
    tick = 1'b1;
    n = 0;
    #1;
    while (!reg_rdata[6] && n < 200) begin
      @(negedge clk); #1; n++;
    end
    chk(n == 2 * TPS, "R4 resumes with ticks", n, 2 * TPS);
    wr(2'd0, cfg_byte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0));

    // R2 restart by rewrite
    wr(2'd0, cfg_byte(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0));
    wr(2'd1, 8'd3);
    repeat (6) @(negedge clk);
    wr(2'd1, 8'd3);
    reg_sel = 2'd0; #1;
    n = 0;
    while (!reg_rdata[6] && n < 200) begin
      @(negedge clk); #1; n++;
    end
    chk(n == 3 * TPS, "R2 reload restarts countdown", n, 3 * TPS);
    wr(2'd0, cfg_byte(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0));

    // directed corners
    run_timeout(1, 1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1);
    run_timeout(2, 1'b1, 1'b1, 1'b0, 3, 1'b1, 1'b0);
    run_timeout(3, 1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b1);

    // constrained random
    for (int i = 0; i < 12; i++) begin
      run_timeout(1 + int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom % 4), 1'($urandom), 1'($urandom));
    end

    summary_and_end();
  end
endmodule